// File: doc/BRIEF.md
# Clock-Driven Serial Memory Streamer

This block holds a small byte array and plays it out one bit at a time, paced only by a dedicated transmit clock that arrives asynchronously from outside. There is no addressing, no start condition and no handshake. The stream simply runs through the array in order and starts again at the first byte after the last one. The transmit clock is oversampled in the system clock domain. Each of its rising edges moves the stream forward by one bit slot.

After reset the block lets the data line float until it has counted a fixed number of transmit-clock pulses. This count gives the receiver time to fall into step. After that, every byte takes one slot per data bit, most significant bit first, followed by one filler slot. During the filler slot and at any time the line is not driven, the output is released so that an open-drain line reads 1. A mode input from the surrounding logic gates the whole stream. While that input is low, the output is released and transmit-clock edges are ignored. When the input returns high, the stream resumes exactly where it stopped.

The array contents are fixed at build time by a parameter. The default fill is all ones, the erased state. A second fill produces an address-dependent test pattern.

Top module: `serial_streamer`

## Requirements
- R1: While reset is held and just after it, sd_oe is 0 and sd_bit is 1.
- R2: The first 9 rising edges of tx_clk after reset leave sd_oe at 0 (sync phase).
- R3: The 10th rising edge makes sd_oe 1 with sd_bit equal to bit 7 (the most significant bit) of the byte at address 0.
- R4: Each byte occupies 9 rising edges. Slots 0..7 drive data bits 7 down to 0, with sd_oe 1. Slot 8 is a filler with sd_oe 0 and sd_bit 1.
- R5: The rising edge after a filler slot drives bit 7 of the byte at the next address.
- R6: After the byte at address 127 (DEPTH-1), the next byte comes from address 0 and streaming continues.
- R7: While stream_en is 0, sd_oe is 0 and sd_bit is 1 in the same cycle, and tx_clk edges do not advance the stream. When stream_en returns to 1, the slot that was current is driven again.
- R8: An output change caused by a tx_clk rising edge appears after the third system-clock rising edge that follows it. Falling edges of tx_clk have no effect.
- R9: With FILL_KIND 0 every byte reads 0xFF. With FILL_KIND 1 the byte at address a is ((37*a + 92) mod 256) XOR (a >> 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_clk | input | 1 | Asynchronous transmit clock that paces the stream |
| stream_en | input | 1 | High while the mode controller reports transmit-only mode |
| sd_oe | output | 1 | Drive enable for the serial data line (1 = drive sd_bit) |
| sd_bit | output | 1 | Serial data bit; 1 whenever sd_oe is 0 |

## Verification
A tx_clk rising edge travels through two synchroniser flops and one edge flop, so the state and the outputs change after the third system-clock edge. The bench drives tx_clk on falling clock edges and waits four falling edges before it samples. One directed case samples after the second edge as well as after the third, to show that the result appears exactly then. The outputs follow stream_en combinationally, so a change of stream_en is checked at the next falling edge. Every other slot is compared after a full high-then-low transmit pulse, against a bit position and address that the bench tracks itself.

// File: rtl/streamer_pkg.sv
package streamer_pkg;

  typedef enum logic {
    PH_SYNC   = 1'b0,
    PH_STREAM = 1'b1
  } phase_t;

  // Fill kinds for the constant array
  localparam int FILL_ERASED  = 0;
  localparam int FILL_PATTERN = 1;

  // Content of one array location for a given fill kind
  function automatic logic [31:0] fill_value(input int kind, input int addr);
    logic [31:0] v;
    if (kind == FILL_PATTERN) begin
      v = (((32'(addr) * 32'd37) + 32'd92) & 32'hFF) ^ (32'(addr) >> 2);
    end else begin
      v = 32'hFFFF_FFFF;
    end
    return v;
  endfunction

  // Next index of a circular counter of the given modulus
  function automatic logic [31:0] wrap_next(input logic [31:0] cur, input logic [31:0] modulus);
    return (cur >= modulus - 32'd1) ? 32'd0 : cur + 32'd1;
  endfunction

endpackage

// File: rtl/tx_edge_sync.sv
module tx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  // chain[0..STAGES-1] synchronise, chain[STAGES] keeps the previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-1:0], async_in};
    end
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

  // R8: one rising edge of the transmit clock gives one single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/stream_sequencer.sv
module stream_sequencer
  import streamer_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int WIDTH       = 8,
  parameter int SYNC_PULSES = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = $clog2(WIDTH + 1),
  localparam int CW = $clog2(SYNC_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic          in_stream,
  output logic [AW-1:0] byte_ptr,
  output logic [BW-1:0] bit_pos,
  output logic          slot_is_data,
  output logic          sync_done_ev,
  output logic          byte_end_ev
);
  phase_t        phase;
  logic [CW-1:0] sync_cnt;

  assign in_stream    = (phase == PH_STREAM);
  assign slot_is_data = in_stream && (bit_pos < BW'(WIDTH));
  assign sync_done_ev = adv && (phase == PH_SYNC) && (sync_cnt == CW'(SYNC_PULSES));
  assign byte_end_ev  = adv && in_stream && (bit_pos == BW'(WIDTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_SYNC;
      sync_cnt <= '0;
      byte_ptr <= '0;
      bit_pos  <= '0;
    end else if (adv) begin
      if (phase == PH_SYNC) begin
        if (sync_done_ev) begin
          phase    <= PH_STREAM;
          byte_ptr <= '0;
          bit_pos  <= '0;
        end else begin
          sync_cnt <= sync_cnt + 1'b1;
        end
      end else if (byte_end_ev) begin
        bit_pos  <= '0;
        byte_ptr <= AW'(wrap_next(32'(byte_ptr), 32'(DEPTH)));
      end else begin
        bit_pos <= bit_pos + 1'b1;
      end
    end
  end

  // R3: the pulse after the sync count starts byte 0 at its top bit
  a_r3_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done_ev |=> in_stream && byte_ptr == '0 && bit_pos == '0);

  // R5: after a filler slot the pointer steps by one
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end_ev && byte_ptr != AW'(DEPTH - 1)) |=> byte_ptr == $past(byte_ptr) + 1'b1);

  // R6: the last location is followed by location 0
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end_ev && byte_ptr == AW'(DEPTH - 1)) |=> byte_ptr == '0);

  // R7: without an accepted edge nothing moves
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(byte_ptr) && $stable(bit_pos) && $stable(phase) && $stable(sync_cnt));

  // R4: the slot index never passes the filler slot
  a_r4_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos <= BW'(WIDTH));

endmodule

// File: rtl/stream_rom.sv
module stream_rom
  import streamer_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int WIDTH     = 8,
  parameter int FILL_KIND = FILL_ERASED,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0]    addr,
  output logic [WIDTH-1:0] data
);
  logic [WIDTH-1:0] cells [DEPTH];

  generate
    if (FILL_KIND == FILL_ERASED) begin : g_erased
      for (genvar a = 0; a < DEPTH; a++) begin : g_cell
        assign cells[a] = '1;
      end
    end else begin : g_pattern
      for (genvar a = 0; a < DEPTH; a++) begin : g_cell
        localparam logic [31:0] CELL_V = fill_value(FILL_KIND, a);
        assign cells[a] = CELL_V[WIDTH-1:0];
      end
    end
  endgenerate

  assign data = cells[addr];

endmodule

// File: rtl/serial_streamer.sv
module serial_streamer
  import streamer_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int WIDTH       = 8,
  parameter int SYNC_PULSES = 9,
  parameter int SYNC_STAGES = 2,
  parameter int FILL_KIND   = FILL_ERASED
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_clk,
  input  logic stream_en,
  output logic sd_oe,
  output logic sd_bit
);
  localparam int AW = $clog2(DEPTH);
  localparam int BW = $clog2(WIDTH + 1);

  logic             tx_rise;
  logic             adv;
  logic             in_stream;
  logic [AW-1:0]    byte_ptr;
  logic [BW-1:0]    bit_pos;
  logic             slot_is_data;
  logic             sync_done_ev;
  logic             byte_end_ev;
  logic [WIDTH-1:0] cur_byte;
  logic             cur_bit;

  tx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (tx_clk),
    .rise     (tx_rise)
  );

  assign adv = tx_rise && stream_en;

  stream_sequencer #(
    .DEPTH       (DEPTH),
    .WIDTH       (WIDTH),
    .SYNC_PULSES (SYNC_PULSES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv          (adv),
    .in_stream    (in_stream),
    .byte_ptr     (byte_ptr),
    .bit_pos      (bit_pos),
    .slot_is_data (slot_is_data),
    .sync_done_ev (sync_done_ev),
    .byte_end_ev  (byte_end_ev)
  );

  stream_rom #(
    .DEPTH     (DEPTH),
    .WIDTH     (WIDTH),
    .FILL_KIND (FILL_KIND)
  ) u_rom (
    .addr (byte_ptr),
    .data (cur_byte)
  );

  // Data bits leave most significant first
  always_comb begin
    cur_bit = 1'b1;
    for (int i = 0; i < WIDTH; i++) begin
      if (bit_pos == BW'(i)) cur_bit = cur_byte[WIDTH-1-i];
    end
  end

  assign sd_oe  = stream_en && slot_is_data;
  assign sd_bit = sd_oe ? cur_bit : 1'b1;

  // R2: no drive during the sync phase
  a_r2_quiet_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stream |-> !sd_oe);

  // R7: a low mode input releases the line
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    !stream_en |-> !sd_oe && sd_bit);

  // R4: filler slot releases the line high
  a_r4_filler: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stream && !slot_is_data) |-> !sd_oe && sd_bit);

  // R1: the line reads high whenever it is not driven
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> sd_bit);

endmodule

// File: tb/test_serial_streamer.sv
module test_serial_streamer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txc = 1'b0;
  logic en = 1'b1;
  logic oe_p, bit_p, oe_e, bit_e;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state kept by the bench
  int  m_sync = 0;
  bit  m_stream = 1'b0;
  int  m_ptr = 0;
  int  m_pos = 0;

  always #10 clk = ~clk;

  serial_streamer #(.FILL_KIND(1)) i_serial_streamer (
    .clk(clk), .rst_n(rst_n), .tx_clk(txc), .stream_en(en),
    .sd_oe(oe_p), .sd_bit(bit_p)
  );

  serial_streamer i_serial_streamer_erased (
    .clk(clk), .rst_n(rst_n), .tx_clk(txc), .stream_en(en),
    .sd_oe(oe_e), .sd_bit(bit_e)
  );

  // R9 pattern written as shifts and adds
  function automatic logic [7:0] pat(input int a);
    int s;
    s = (a << 5) + (a << 2) + a + 92;
    return 8'(s % 256) ^ 8'(a / 4);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (ptr=%0d pos=%0d)", tag, act, exp, m_ptr, m_pos);
    end
  endtask

  task automatic model_step();
    if (!en) return;
    if (!m_stream) begin
      if (m_sync == 9) begin m_stream = 1'b1; m_ptr = 0; m_pos = 0; end
      else m_sync++;
    end else if (m_pos == 8) begin
      m_pos = 0; m_ptr = (m_ptr + 1) % 128;
    end else m_pos++;
  endtask

  task automatic compare_outputs(input string tag);
    logic eo, eb;
    eo = en && m_stream && (m_pos < 8);
    eb = eo ? pat(m_ptr)[7 - m_pos] : 1'b1;
    chk({tag, " oe"}, {7'd0, oe_p}, {7'd0, eo});
    chk({tag, " bit"}, {7'd0, bit_p}, {7'd0, eb});
    chk({tag, " R9 erased oe"}, {7'd0, oe_e}, {7'd0, eo});
    chk({tag, " R9 erased bit"}, {7'd0, bit_e}, 8'd1);
  endtask

  task automatic pulse();
    @(negedge clk) txc = 1'b1;
    repeat (4) @(negedge clk);
    txc = 1'b0;
    repeat (4) @(negedge clk);
    model_step();
  endtask

  task automatic pulse_check(input string tag);
    string t;
    int prev_ptr;
    prev_ptr = m_ptr;
    pulse();
    t = tag;
    if (m_stream && m_pos == 8) t = "R4 filler";
    else if (m_stream && m_pos == 0 && m_ptr == 0 && prev_ptr == 127) t = "R6 wrap";
    else if (m_stream && m_pos == 0 && m_ptr != prev_ptr) t = "R5 next byte";
    compare_outputs(t);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", {7'd0, oe_p}, 8'd0);
    chk("R1 bit in reset", {7'd0, bit_p}, 8'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 oe after reset", {7'd0, oe_p}, 8'd0);
  endtask

  task automatic t_sync();
    for (int i = 0; i < 9; i++) pulse_check("R2 sync");
  endtask

  task automatic t_latency();
    @(negedge clk) txc = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 not yet after 2 edges", {7'd0, oe_p}, 8'd0);
    @(negedge clk);
    chk("R3 oe on 10th edge", {7'd0, oe_p}, 8'd1);
    chk("R3 msb of byte 0", {7'd0, bit_p}, {7'd0, pat(0)[7]});
    @(negedge clk) txc = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 falling edge no effect oe", {7'd0, oe_p}, 8'd1);
    chk("R8 falling edge no effect bit", {7'd0, bit_p}, {7'd0, pat(0)[7]});
    model_step();
  endtask

  task automatic t_bytes();
    for (int i = 0; i < 3 * 9; i++) pulse_check("R4 data");
  endtask

  task automatic t_enable();
    int hold_pos, hold_ptr;
    for (int i = 0; i < 3; i++) pulse_check("R4 data");
    hold_pos = m_pos; hold_ptr = m_ptr;
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    chk("R7 oe released", {7'd0, oe_p}, 8'd0);
    chk("R7 bit high", {7'd0, bit_p}, 8'd1);
    for (int i = 0; i < 5; i++) pulse_check("R7 disabled");
    @(negedge clk) en = 1'b1;
    @(negedge clk);
    chk("R7 model held pos", 8'(m_pos), 8'(hold_pos));
    chk("R7 model held ptr", 8'(m_ptr), 8'(hold_ptr));
    compare_outputs("R7 resume");
  endtask

  task automatic t_wrap();
    while (!(m_ptr == 1 && m_pos == 8)) pulse_check("R4 data");
  endtask

  initial begin
    t_reset();
    t_sync();
    t_latency();
    t_bytes();
    t_enable();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule